// File: doc/BRIEF.md
# Dual-Port Word Memory with Address-Contention Arbitration

This block is a true dual-port memory. Two independent ports, left and right, can read and write it in the same clock cycle. Each port has its own enable, write select, output enable, per-byte lane enables, address, write data, registered read data and a busy flag. The word is built from `LANES` byte lanes of 8 bits each. The default is two lanes, giving a 16-bit word. The depth is `2**ADDR_W` words: `ADDR_W = 14` gives 16K words, and the default is kept smaller so the block elaborates quickly.

An arbiter watches both ports. When both ports are enabled on the same word, the port that reached that word first keeps access. The other port is flagged busy, and its writes are held off. A busy port that keeps its write request asserted completes the write once the conflict clears.

With `is_master` high, the local arbiter drives the busy flags and presents them on the busy outputs. With `is_master` low, the local arbiter is bypassed. Each port then takes its busy state from its busy input, and both busy outputs stay low. This lets several instances be placed side by side to form a wider word, with one master deciding for all of them.

Top module: `dpr_contention_ram`

## Requirements
- R1: A read, meaning enable high, write select low and output enable high, returns the addressed word on that port's read data one cycle later. In the cycle after any non-read, and after reset, read data is all zero.
- R2: Both ports reading the same address in the same cycle each receive the stored word.
- R3: Byte enable bit g selects data bits [8g+7:8g]; bit 0 is the low byte. A write changes only the selected lanes. On a read, the unselected lanes return zero.
- R4: With both ports enabled on the same address, exactly the losing port's busy is high in that same cycle, with no register delay. Busy drops as soon as the addresses differ or either enable goes low.
- R5: The port that was already enabled on the address in the previous cycle wins, and the other port is busy. If both arrive in the same cycle, the left port wins. The decision holds while the match lasts, and at most one port is busy.
- R6: A busy port that reads still receives read data.
- R7: A write from a busy port leaves the memory unchanged.
- R8: A blocked write whose request is held completes on the first cycle its port is no longer busy.
- R9: A read in the same cycle as the other port's write to the same address returns the data from before that write.
- R10: With `is_master` low, each port's busy comes only from its busy input and blocks that port's writes, the address match has no effect, and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1: local arbiter decides; 0: busy taken from the inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable for reads |
| l_be | input | LANES | Left byte lane enables |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 8*LANES | Left write data |
| l_rdata | output | 8*LANES | Left registered read data |
| l_busy_in | input | 1 | Left busy from a master (used when is_master = 0) |
| l_busy_out | output | 1 | Left busy flag from the local arbiter |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable for reads |
| r_be | input | LANES | Right byte lane enables |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 8*LANES | Right write data |
| r_rdata | output | 8*LANES | Right registered read data |
| r_busy_in | input | 1 | Right busy from a master (used when is_master = 0) |
| r_busy_out | output | 1 | Right busy flag from the local arbiter |

## Verification
The bench drives contention in three arrival orders: left first, right first, and both in the same cycle. A design that chose the winner by port number alone, or that re-decided the winner every cycle, would flag the wrong side in at least one of these. After a busy write has been refused, the bench reads the word back and then releases the conflict with the request still held. A design that let the write through early shows the new word too soon, and one that dropped the request never shows it at all. The bench also reads a word in the same cycle the other port writes it, to catch a write-first memory. Slave mode is driven with a busy input that has no address match behind it, and with a match that has no busy input behind it, to show the local comparator really is bypassed.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int LANE_W = 8;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              busy_l,
  output logic              busy_r
);

  logic              prev_en_l, prev_en_r;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  logic              match, match_q;
  logic              stay_l, stay_r;
  side_e             winner, winner_q, winner_new;

  assign match  = en_l && en_r && (addr_l == addr_r);
  // A port "stays" when it was already enabled on this address last cycle.
  assign stay_l = prev_en_l && (prev_addr_l == addr_l);
  assign stay_r = prev_en_r && (prev_addr_r == addr_r);

  // The right port wins only if it stayed and the left did not; ties go left.
  assign winner_new = (stay_r && !stay_l) ? SIDE_RIGHT : SIDE_LEFT;
  assign winner     = match_q ? winner_q : winner_new;

  assign busy_l = match && (winner == SIDE_RIGHT);
  assign busy_r = match && (winner == SIDE_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en_l   <= 1'b0;
      prev_en_r   <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      match_q     <= 1'b0;
      winner_q    <= SIDE_LEFT;
    end else begin
      prev_en_l   <= en_l;
      prev_en_r   <= en_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      match_q     <= match;
      winner_q    <= winner;
    end
  end

  a_r5_one_loser: assert property (@(posedge clk) disable iff (rst)
    !(busy_l && busy_r));

  a_r4_release_on_disable: assert property (@(posedge clk) disable iff (rst)
    (!en_l || !en_r) |-> (!busy_l && !busy_r));

  a_r5_decision_held: assert property (@(posedge clk) disable iff (rst)
    (match && match_q) |-> (busy_l == $past(busy_l) && busy_r == $past(busy_r)));

  a_r5_first_arrival_wins: assert property (@(posedge clk) disable iff (rst)
    (match && !match_q && stay_l && !stay_r) |-> busy_r);

endmodule

// File: rtl/dpr_lane_mem.sv
module dpr_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [W-1:0]      din_a,
  output logic [W-1:0]      dout_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [W-1:0]      din_b,
  output logic [W-1:0]      dout_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  // Port b is written first so that port a lands last on an unarbitrated collision.
  always_ff @(posedge clk) begin
    if (wr_b) mem[addr_b] <= din_b;
    if (wr_a) mem[addr_a] <= din_a;
  end

  // Reads always sample the value held before this edge's writes.
  always_ff @(posedge clk) begin
    dout_a <= mem[addr_a];
    dout_b <= mem[addr_b];
  end

endmodule

// File: rtl/dpr_contention_ram.sv
module dpr_contention_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    is_master,
  input  logic                    l_en,
  input  logic                    l_we,
  input  logic                    l_oe,
  input  logic [LANES-1:0]        l_be,
  input  logic [ADDR_W-1:0]       l_addr,
  input  logic [LANES*LANE_W-1:0] l_wdata,
  output logic [LANES*LANE_W-1:0] l_rdata,
  input  logic                    l_busy_in,
  output logic                    l_busy_out,
  input  logic                    r_en,
  input  logic                    r_we,
  input  logic                    r_oe,
  input  logic [LANES-1:0]        r_be,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic [LANES*LANE_W-1:0] r_wdata,
  output logic [LANES*LANE_W-1:0] r_rdata,
  input  logic                    r_busy_in,
  output logic                    r_busy_out
);

  localparam int DATA_W = LANES * LANE_W;

  logic              arb_busy_l, arb_busy_r;
  logic              busy_l, busy_r;
  logic              l_wr, r_wr, l_rd, r_rd;
  logic [LANES-1:0]  l_rsel_q, r_rsel_q;
  logic [DATA_W-1:0] l_raw, r_raw, l_mask, r_mask;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .en_l   (l_en),
    .addr_l (l_addr),
    .en_r   (r_en),
    .addr_r (r_addr),
    .busy_l (arb_busy_l),
    .busy_r (arb_busy_r)
  );

  assign busy_l     = is_master ? arb_busy_l : l_busy_in;
  assign busy_r     = is_master ? arb_busy_r : r_busy_in;
  assign l_busy_out = is_master && arb_busy_l;
  assign r_busy_out = is_master && arb_busy_r;

  assign l_wr = l_en && l_we && !busy_l;
  assign r_wr = r_en && r_we && !busy_r;
  assign l_rd = l_en && !l_we && l_oe;
  assign r_rd = r_en && !r_we && r_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_rsel_q <= '0;
      r_rsel_q <= '0;
    end else begin
      l_rsel_q <= l_rd ? l_be : '0;
      r_rsel_q <= r_rd ? r_be : '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpr_lane_mem #(.ADDR_W(ADDR_W), .W(LANE_W)) u_mem (
      .clk    (clk),
      .wr_a   (l_wr && l_be[g]),
      .addr_a (l_addr),
      .din_a  (l_wdata[g*LANE_W +: LANE_W]),
      .dout_a (l_raw[g*LANE_W +: LANE_W]),
      .wr_b   (r_wr && r_be[g]),
      .addr_b (r_addr),
      .din_b  (r_wdata[g*LANE_W +: LANE_W]),
      .dout_b (r_raw[g*LANE_W +: LANE_W])
    );
    assign l_mask[g*LANE_W +: LANE_W] = {LANE_W{l_rsel_q[g]}};
    assign r_mask[g*LANE_W +: LANE_W] = {LANE_W{r_rsel_q[g]}};
  end

  assign l_rdata = l_raw & l_mask;
  assign r_rdata = r_raw & r_mask;

  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    !is_master |-> (!l_busy_out && !r_busy_out));

  a_r1_left_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(l_en && !l_we && l_oe) |=> (l_rdata == '0));

  a_r1_right_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(r_en && !r_we && r_oe) |=> (r_rdata == '0));

endmodule

// File: tb/test_dpr_contention_ram.sv
module test_dpr_contention_ram;

  localparam int AW = 10;
  localparam int NL = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          is_master = 1'b1;
  logic          l_en = 0, l_we = 0, l_oe = 0, l_busy_in = 0;
  logic [NL-1:0] l_be = '0;
  logic [AW-1:0] l_addr = '0;
  logic [DW-1:0] l_wdata = '0;
  logic          r_en = 0, r_we = 0, r_oe = 0, r_busy_in = 0;
  logic [NL-1:0] r_be = '0;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_out, r_busy_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dpr_contention_ram #(.ADDR_W(AW), .LANES(NL)) i_dpr_contention_ram (
    .clk(clk), .rst(rst), .is_master(is_master),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_be(l_be), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_be(r_be), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv_l(input logic en, input logic we, input logic oe, input logic [NL-1:0] be,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = en; l_we = we; l_oe = oe; l_be = be; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic en, input logic we, input logic oe, input logic [NL-1:0] be,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = en; r_we = we; r_oe = oe; r_be = be; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, '0, '0, '0);
    drv_r(0, 0, 0, '0, '0, '0);
  endtask

  task automatic wr_left(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] be);
    drv_l(1, 1, 0, be, a, d); tick(); idle();
  endtask

  task automatic rd_left(input logic [AW-1:0] a, input logic [NL-1:0] be, output logic [DW-1:0] q);
    drv_l(1, 0, 1, be, a, '0); tick(); q = l_rdata; idle();
  endtask

  task automatic rd_right(input logic [AW-1:0] a, input logic [NL-1:0] be, output logic [DW-1:0] q);
    drv_r(1, 0, 1, be, a, '0); tick(); q = r_rdata; idle();
  endtask

  task automatic t_reset();
    chk("R1 reset left rdata", l_rdata, '0);
    chk("R1 reset right rdata", r_rdata, '0);
    chk("R4 reset busy", {15'd0, l_busy_out | r_busy_out}, '0);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] q;
    wr_left(6, 16'hAAAA, 2'b11);
    wr_left(6, 16'h0011, 2'b01);
    wr_left(6, 16'h2200, 2'b10);
    rd_right(6, 2'b11, q);
    chk("R3 lane merge", q, 16'h2211);
    rd_right(6, 2'b01, q);
    chk("R3 read low lane only", q, 16'h0011);
    drv_l(1, 0, 0, 2'b11, 6, '0); tick(); q = l_rdata; idle();
    chk("R1 output enable low reads zero", q, '0);
    rd_left(6, 2'b11, q);
    chk("R1 full read", q, 16'h2211);
  endtask

  task automatic t_same_read();
    wr_left(5, 16'hC35A, 2'b11);
    drv_l(1, 0, 1, 2'b11, 5, '0);
    drv_r(1, 0, 1, 2'b11, 5, '0);
    tick();
    chk("R2 left same-address read", l_rdata, 16'hC35A);
    chk("R2 right same-address read", r_rdata, 16'hC35A);
    idle(); tick();
  endtask

  task automatic t_left_first();
    logic [DW-1:0] q;
    wr_left(20, 16'h0F0F, 2'b11);
    drv_l(1, 0, 1, 2'b11, 20, '0); tick();
    drv_r(1, 1, 0, 2'b11, 20, 16'h1234); #1;
    chk("R5 left first: right busy", {15'd0, r_busy_out}, 16'd1);
    chk("R5 left first: left clear", {15'd0, l_busy_out}, 16'd0);
    tick(); tick();
    chk("R7 blocked write leaves word", l_rdata, 16'h0F0F);
    chk("R5 decision held", {15'd0, r_busy_out}, 16'd1);
    drv_l(0, 0, 0, '0, '0, '0); #1;
    chk("R4 release on enable low", {15'd0, r_busy_out}, 16'd0);
    tick(); idle();
    rd_left(20, 2'b11, q);
    chk("R8 deferred write completes", q, 16'h1234);
  endtask

  task automatic t_right_first();
    logic [DW-1:0] q;
    wr_left(30, 16'h3030, 2'b11);
    drv_r(1, 0, 1, 2'b11, 30, '0); tick();
    drv_l(1, 1, 0, 2'b11, 30, 16'hBEEF); #1;
    chk("R5 right first: left busy", {15'd0, l_busy_out}, 16'd1);
    chk("R5 right first: right clear", {15'd0, r_busy_out}, 16'd0);
    tick(); tick();
    chk("R7 right reads unchanged word", r_rdata, 16'h3030);
    drv_r(1, 0, 1, 2'b11, 31, '0); #1;
    chk("R4 release on address change", {15'd0, l_busy_out}, 16'd0);
    tick(); idle();
    rd_right(30, 2'b11, q);
    chk("R8 deferred left write completes", q, 16'hBEEF);
  endtask

  task automatic t_tie();
    logic [DW-1:0] q;
    drv_l(1, 1, 0, 2'b11, 40, 16'h5555);
    drv_r(1, 1, 0, 2'b11, 40, 16'h6666); #1;
    chk("R5 tie: right busy", {15'd0, r_busy_out}, 16'd1);
    chk("R5 tie: left clear", {15'd0, l_busy_out}, 16'd0);
    tick(); idle();
    rd_left(40, 2'b11, q);
    chk("R7 tie: only winner written", q, 16'h5555);
  endtask

  task automatic t_read_old();
    wr_left(50, 16'h1111, 2'b11);
    drv_l(1, 1, 0, 2'b11, 50, 16'h7777);
    drv_r(1, 0, 1, 2'b11, 50, '0); #1;
    chk("R6 reading port flagged busy", {15'd0, r_busy_out}, 16'd1);
    tick();
    chk("R9 R6 busy read returns old data", r_rdata, 16'h1111);
    drv_l(0, 0, 0, '0, '0, '0);
    tick();
    chk("R1 read sees new data next cycle", r_rdata, 16'h7777);
    idle(); tick();
  endtask

  task automatic t_slave();
    logic [DW-1:0] q;
    is_master = 1'b0;
    wr_left(60, 16'h6060, 2'b11);
    r_busy_in = 1'b1;
    drv_r(1, 1, 0, 2'b11, 60, 16'h9999); #1;
    chk("R10 slave busy out low", {15'd0, l_busy_out | r_busy_out}, 16'd0);
    tick(); idle();
    rd_left(60, 2'b11, q);
    chk("R10 busy input blocks write", q, 16'h6060);
    r_busy_in = 1'b0;
    drv_r(1, 1, 0, 2'b11, 60, 16'h9999); tick(); idle();
    rd_left(60, 2'b11, q);
    chk("R10 write lands once input clear", q, 16'h9999);
    wr_left(61, 16'h0A0A, 2'b11);
    drv_l(1, 0, 1, 2'b11, 61, '0);
    drv_r(1, 1, 0, 2'b11, 61, 16'h0B0B); #1;
    chk("R10 match ignored in slave", {15'd0, l_busy_out | r_busy_out}, 16'd0);
    tick(); idle();
    rd_left(61, 2'b11, q);
    chk("R10 unarbitrated write lands", q, 16'h0B0B);
    is_master = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_bytes();
    t_same_read();
    t_left_first();
    t_right_first();
    t_tie();
    t_read_old();
    t_slave();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule